// File: doc/BRIEF.md
# Byte-Wide Host to 16-Bit Disk Bus Bridge

This block lets an 8-bit host bus talk to a 16-bit parallel ATA device. The host sees a 32-byte I/O window. The lower half of the window reaches the device's register blocks: address bit 3 picks the command block or the control block, and address bits 2..0 go straight to the device's three register-address lines. The upper half reaches two 8-bit side registers that carry the upper data byte. One register holds the high byte staged for the next device write. The other holds the high byte captured from the last device read.

The whole block runs on the fast dot clock. The host's bus-phase clock is sampled as an ordinary input. The device chip selects follow the phase at once. The read and write strobes wait for the phase to pass through a short flop chain, so the device sees a settled select and address before any strobe begins. A 16-bit transfer therefore takes two byte accesses. A write stages the high byte in the side window and then writes the low byte to the data port. A read takes the low byte from the data port and then fetches the captured high byte from the side window.

The host and device data buses are given as separate in, out and output-enable signals. Pad-level tri-state buffers are built outside the block.

Top module: `ide_byte_bridge`

## Requirements
- R1: While `win_sel` and `phi` are high and `addr[4]`=0, exactly one block select is low: `dev_cs0_n` when `addr[3]`=0 and `dev_cs1_n` when `addr[3]`=1. Both selects are never low together.
- R2: While `addr[4]`=1, both block selects and both strobes stay high.
- R3: `dev_addr` always equals `addr[2:0]`.
- R4: A device strobe goes low only once `phi` has been high at a rising dot-clock edge, and it goes high again as soon as `phi` falls. Its direction follows `rw` (1 = read: `dev_ior_n`; 0 = write: `dev_iow_n`).
- R5: While `dev_iow_n` is low, `dev_d_oe`=1 and `dev_d_out` = {write-high register, `host_d_in`}. At all other times `dev_d_oe`=0.
- R6: During a device read with `addr[4]`=0, `host_d_out` = `dev_d_in[7:0]`. On every dot-clock edge where `dev_ior_n` is low, the read-high register loads `dev_d_in[15:8]`, so it keeps the value from the last edge of the strobe.
- R7: A write with `addr[4]`=1 loads `host_d_in` into the write-high register on every edge where `win_sel`, `phi` and the delayed phase are all high.
- R8: A read with `addr[4]`=1 returns the read-high register on `host_d_out`.
- R9: `host_d_oe` is 1 only when `win_sel`, `phi` and `rw` are all high.
- R10: Reset clears both high-byte registers to 0x00 and clears the phase delay.
- R11: With `win_sel` low, no select, strobe or output enable is active, and neither high-byte register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock; clocks the phase delay and the high-byte registers |
| rst | input | 1 | Synchronous active-high reset |
| phi | input | 1 | Host bus-phase clock; a high level marks the active phase |
| win_sel | input | 1 | Host window select, active high |
| addr | input | 5 | Host offset in the 32-byte window |
| rw | input | 1 | Host direction: 1 = read, 0 = write |
| host_d_in | input | 8 | Byte the host drives |
| host_d_out | output | 8 | Byte returned to the host |
| host_d_oe | output | 1 | Drive enable for the host data bus |
| dev_cs0_n | output | 1 | Command block select, active low |
| dev_cs1_n | output | 1 | Control block select, active low |
| dev_addr | output | 3 | Device register address |
| dev_ior_n | output | 1 | Device read strobe, active low |
| dev_iow_n | output | 1 | Device write strobe, active low |
| dev_d_in | input | 16 | Word the device drives |
| dev_d_out | output | 16 | Word driven to the device |
| dev_d_oe | output | 1 | Drive enable for the device data bus |

## Verification
A behavioural model is compared with the design on every dot clock. It is driven through three kinds of traffic: data-port transfers in both directions, side-window accesses, and accesses to every register offset of both blocks. The data-port transfers show whether the two halves of the word reach the correct register and lane. The side-window accesses show whether the device stays quiet while only the holding registers move. The sweep over all offsets separates the block selects and checks that the address lines are passed through unchanged. Accesses with the window deselected, and phases of different lengths, check that the strobe starts late, ends at the phase edge, and that nothing moves outside the window.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
    localparam int HB_W     = 8;
    localparam int DEV_W    = 2 * HB_W;
    localparam int REG_AW   = 3;
    localparam int WIN_AW   = REG_AW + 2;
    localparam int BLK_BIT  = REG_AW;
    localparam int SIDE_BIT = REG_AW + 1;

    typedef struct packed {
        logic cs0_n;
        logic cs1_n;
        logic ior_n;
        logic iow_n;
    } dev_ctl_t;

    // returns {cs1_n, cs0_n}
    function automatic logic [1:0] blk_sel_n(input logic act, input logic blk);
        return {~(act & blk), ~(act & ~blk)};
    endfunction
endpackage

// File: rtl/ibb_phase_delay.sv
module ibb_phase_delay #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic phi,
    output logic phi_dly
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= phi;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign phi_dly = chain_q[STAGES-1];

    p_dly_clear_r10: assert property (@(posedge clk) rst |=> !phi_dly);
endmodule

// File: rtl/ibb_decode.sv
module ibb_decode
    import ibb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              win_sel,
    input  logic              phi,
    input  logic              phi_dly,
    input  logic              rw,
    input  logic [WIN_AW-1:0] addr,
    output dev_ctl_t          ctl,
    output logic              latch_wr,
    output logic              side_rd,
    output logic              host_oe
);
    logic dev_phase, strobe;

    always_comb begin
        dev_phase = win_sel & phi & ~addr[SIDE_BIT];
        strobe    = dev_phase & phi_dly;
        {ctl.cs1_n, ctl.cs0_n} = blk_sel_n(dev_phase, addr[BLK_BIT]);
        ctl.ior_n = ~(strobe & rw);
        ctl.iow_n = ~(strobe & ~rw);
        latch_wr  = win_sel & phi & phi_dly & addr[SIDE_BIT] & ~rw;
        side_rd   = addr[SIDE_BIT];
        host_oe   = win_sel & phi & rw;
    end

    p_side_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        addr[SIDE_BIT] |-> (ctl.cs0_n && ctl.cs1_n && ctl.ior_n && ctl.iow_n));
    p_one_block_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~ctl.cs0_n, ~ctl.cs1_n}));
endmodule

// File: rtl/ibb_hi_stage.sv
module ibb_hi_stage
    import ibb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            latch_wr,
    input  logic [HB_W-1:0] host_byte,
    input  logic            rd_cap,
    input  logic [HB_W-1:0] dev_hi,
    output logic [HB_W-1:0] wr_hi,
    output logic [HB_W-1:0] rd_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_hi <= '0;
            rd_hi <= '0;
        end else begin
            if (latch_wr) wr_hi <= host_byte;
            if (rd_cap)   rd_hi <= dev_hi;
        end
    end

    p_rd_capture_r6: assert property (@(posedge clk) disable iff (rst)
        rd_cap |=> rd_hi == $past(dev_hi));
    p_wr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !latch_wr |=> $stable(wr_hi));
endmodule

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge
    import ibb_pkg::*;
#(
    parameter int DLY_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi,
    input  logic              win_sel,
    input  logic [WIN_AW-1:0] addr,
    input  logic              rw,
    input  logic [HB_W-1:0]   host_d_in,
    output logic [HB_W-1:0]   host_d_out,
    output logic              host_d_oe,
    output logic              dev_cs0_n,
    output logic              dev_cs1_n,
    output logic [REG_AW-1:0] dev_addr,
    output logic              dev_ior_n,
    output logic              dev_iow_n,
    input  logic [DEV_W-1:0]  dev_d_in,
    output logic [DEV_W-1:0]  dev_d_out,
    output logic              dev_d_oe
);
    logic            phi_dly, latch_wr, side_rd;
    dev_ctl_t        ctl;
    logic [HB_W-1:0] wr_hi, rd_hi;

    ibb_phase_delay #(.STAGES(DLY_STAGES)) u_dly (
        .clk(clk), .rst(rst), .phi(phi), .phi_dly(phi_dly)
    );

    ibb_decode u_dec (
        .clk(clk), .rst(rst), .win_sel(win_sel), .phi(phi), .phi_dly(phi_dly),
        .rw(rw), .addr(addr), .ctl(ctl), .latch_wr(latch_wr),
        .side_rd(side_rd), .host_oe(host_d_oe)
    );

    ibb_hi_stage u_hi (
        .clk(clk), .rst(rst), .latch_wr(latch_wr), .host_byte(host_d_in),
        .rd_cap(~ctl.ior_n), .dev_hi(dev_d_in[DEV_W-1:HB_W]),
        .wr_hi(wr_hi), .rd_hi(rd_hi)
    );

    assign dev_cs0_n  = ctl.cs0_n;
    assign dev_cs1_n  = ctl.cs1_n;
    assign dev_ior_n  = ctl.ior_n;
    assign dev_iow_n  = ctl.iow_n;
    assign dev_addr   = addr[REG_AW-1:0];
    assign dev_d_out  = {wr_hi, host_d_in};
    assign dev_d_oe   = ~ctl.iow_n;
    assign host_d_out = side_rd ? rd_hi : dev_d_in[HB_W-1:0];

    p_strobe_late_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(phi) |-> (dev_ior_n && dev_iow_n));
    p_wr_lane_r5: assert property (@(posedge clk) disable iff (rst)
        !dev_iow_n |-> (dev_d_oe && dev_d_out[HB_W-1:0] == host_d_in));
    p_host_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !win_sel |-> (!host_d_oe && dev_cs0_n && dev_cs1_n));
endmodule

// File: tb/ide_byte_bridge_bench.sv
module ide_byte_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi = 1'b0, win_sel = 1'b0, rw = 1'b1;
    logic [4:0]  addr = '0;
    logic [7:0]  host_d_in = '0;
    logic [15:0] dev_d_in = '0;
    logic [7:0]  host_d_out;
    logic        host_d_oe, dev_cs0_n, dev_cs1_n, dev_ior_n, dev_iow_n, dev_d_oe;
    logic [2:0]  dev_addr;
    logic [15:0] dev_d_out;

    int tests = 0, fails = 0;
    bit done = 0;
    logic       m_phq = 0;
    logic [7:0] m_wr = 0, m_rd = 0;
    logic [7:0]  last_host;
    logic [15:0] last_dev;

    always #4 clk = ~clk;

    ide_byte_bridge u_ide_byte_bridge (
        .clk(clk), .rst(rst), .phi(phi), .win_sel(win_sel), .addr(addr), .rw(rw),
        .host_d_in(host_d_in), .host_d_out(host_d_out), .host_d_oe(host_d_oe),
        .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n), .dev_addr(dev_addr),
        .dev_ior_n(dev_ior_n), .dev_iow_n(dev_iow_n), .dev_d_in(dev_d_in),
        .dev_d_out(dev_d_out), .dev_d_oe(dev_d_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: register updates
    always @(posedge clk) begin
        if (rst) begin
            m_phq <= 0; m_wr <= 0; m_rd <= 0;
        end else begin
            if (win_sel && phi && !addr[4] && m_phq && rw) m_rd <= dev_d_in[15:8];
            if (win_sel && phi && addr[4] && m_phq && !rw) m_wr <= host_d_in;
            m_phq <= phi;
        end
    end

    // reference model: per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            bit dev, str;
            dev = win_sel && phi && !addr[4];
            str = dev && m_phq;
            chk(dev_cs0_n == !(dev && !addr[3]), "R1 cs0", dev_cs0_n, !(dev && !addr[3]));
            chk(dev_cs1_n == !(dev && addr[3]), "R1 cs1", dev_cs1_n, !(dev && addr[3]));
            chk(dev_addr == addr[2:0], "R3 addr", dev_addr, addr[2:0]);
            chk(dev_ior_n == !(str && rw), "R4 ior", dev_ior_n, !(str && rw));
            chk(dev_iow_n == !(str && !rw), "R4 iow", dev_iow_n, !(str && !rw));
            chk(dev_d_oe == (str && !rw), "R5 dev oe", dev_d_oe, str && !rw);
            if (str && !rw)
                chk(dev_d_out == {m_wr, host_d_in}, "R5 dev data", dev_d_out, {m_wr, host_d_in});
            chk(host_d_oe == (win_sel && phi && rw), "R9 host oe", host_d_oe, win_sel && phi && rw);
            if (win_sel && phi && rw) begin
                if (addr[4]) chk(host_d_out == m_rd, "R8 side read", host_d_out, m_rd);
                else chk(host_d_out == dev_d_in[7:0], "R6 low byte", host_d_out, dev_d_in[7:0]);
            end
            if (!win_sel)
                chk(dev_cs0_n && dev_cs1_n && dev_ior_n && dev_iow_n && !host_d_oe,
                    "R11 idle", {dev_cs0_n, dev_cs1_n, dev_ior_n, dev_iow_n}, 4'hf);
            if (addr[4])
                chk(dev_cs0_n && dev_cs1_n && dev_ior_n && dev_iow_n,
                    "R2 side quiet", {dev_cs0_n, dev_cs1_n, dev_ior_n, dev_iow_n}, 4'hf);
        end
    end

    task automatic access(input bit w, input logic [4:0] a, input bit r,
                          input logic [7:0] hd, input logic [15:0] dd, input int hi_len);
        @(posedge clk); #2;
        win_sel = w; addr = a; rw = r; host_d_in = hd; dev_d_in = dd; phi = 0;
        @(posedge clk); #2;
        phi = 1;
        for (int i = 0; i < hi_len; i++) begin
            @(negedge clk); #1;
            last_host = host_d_out; last_dev = dev_d_out;
            @(posedge clk); #2;
        end
        phi = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R10: reset contents read back through the side window
        access(1, 5'h10, 1, 8'h00, 16'hFFFF, 3);
        chk(last_host == 8'h00, "R10 rd_hi reset", last_host, 8'h00);
        access(1, 5'h00, 0, 8'h11, 16'h0000, 3);
        chk(last_dev == 16'h0011, "R10 wr_hi reset", last_dev, 16'h0011);
        // R7 / R5: staged write
        access(1, 5'h10, 0, 8'hA5, 16'h0000, 3);
        access(1, 5'h00, 0, 8'h3C, 16'h0000, 4);
        chk(last_dev == 16'hA53C, "R5 R7 word write", last_dev, 16'hA53C);
        // R6 / R8: word read
        access(1, 5'h00, 1, 8'h00, 16'h7E81, 4);
        chk(last_host == 8'h81, "R6 low byte", last_host, 8'h81);
        access(1, 5'h10, 1, 8'h00, 16'h0000, 3);
        chk(last_host == 8'h7E, "R8 high byte", last_host, 8'h7E);
        // R11: deselected accesses change nothing
        access(0, 5'h10, 0, 8'h55, 16'h0000, 3);
        access(0, 5'h00, 1, 8'h00, 16'hC3C3, 3);
        access(1, 5'h10, 1, 8'h00, 16'h0000, 2);
        chk(last_host == 8'h7E, "R11 rd_hi kept", last_host, 8'h7E);
        access(1, 5'h00, 0, 8'h01, 16'h0000, 2);
        chk(last_dev == 16'hA501, "R11 wr_hi kept", last_dev, 16'hA501);
        // R1 / R3 / R4: every device offset, both directions, varied phase length
        for (int k = 0; k < 16; k++)
            access(1, 5'(k), k[0], 8'(k * 7), 16'(k * 16'h1357), 1 + (k % 4));
        // R2: side writes with odd phase lengths
        access(1, 5'h1F, 0, 8'h99, 16'h0000, 1);
        access(1, 5'h18, 0, 8'h66, 16'h0000, 5);
        access(1, 5'h00, 0, 8'h22, 16'h0000, 2);
        chk(last_dev == 16'h6622, "R7 latest staged", last_dev, 16'h6622);
        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule